// File: doc/BRIEF.md
# Two-Way Store-Through Data Cache

This block sits between a load/store unit and a pipelined Wishbone master port. It keeps 32 sets of two ways each. Every line holds four 32-bit words. Each set has a one-bit pseudo-LRU victim pointer. Loads that hit are answered from tag and data arrays whose read result passes through one output register. Hits therefore stream at one per cycle and do not stall. A load that misses fetches the whole line from the bus and then answers with the word that was asked for.

Stores are always written through to the bus as a single write beat. A store that finds its line present also merges its enabled bytes into the cached copy. A store that misses allocates nothing. A request flagged non-cacheable bypasses the arrays and becomes one bus beat.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields must be held until then. `req_ready` falls while a miss, a store or a non-cacheable access is being decided or is on the bus. The response side carries no back-pressure: the requester takes `rsp_data` in any cycle where `rsp_valid` is high. Only loads produce a response.

Top module: `dc_cache`

## Requirements
- R1: After reset `req_ready` is 1, and both `rsp_valid` and `wb_cyc` are 0. Every line is invalid, so the first load to any address misses.
- R2: A cacheable load that hits raises `rsp_valid` with the correct word exactly two cycles after the edge that accepted it, and causes no bus beat.
- R3: Loads that hit can be accepted on consecutive cycles with `req_ready` staying high, and their responses come back on consecutive cycles in request order.
- R4: A cacheable load miss issues one bus read beat per word of the line, at consecutive word addresses starting at the line-aligned address. `req_ready` stays low (and no request is taken) until the refill ends. `rsp_valid` is raised the cycle after the last acknowledge, carrying the requested word.
- R5: At the end of a refill, the tag and valid bit are written into the way that was chosen when the miss began. Later loads to that line hit, and a line is present in at most one way of its set.
- R6: Each set keeps one victim bit. A hit or a refill in way w sets the victim to the other way. A miss replaces the way the bit names, so with three lines competing for one set, the line most recently used survives.
- R7: Every store issues exactly one write beat with its byte enables and produces no response. If the line is present, only the bytes whose `req_sel` bit is 1 (bit b covers data bits 8b+7..8b) change in the cached word.
- R8: A store that misses does not allocate a line: a later load to that line misses and refills, returning the stored data.
- R9: A request with `req_nc` = 1 makes exactly one bus beat and neither reads nor changes the arrays. A non-cacheable load to an absent line does not make it present, and one to a present line leaves that line hitting.
- R10: While `wb_stb` is high and `wb_stall` is high, the strobe and address hold unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_we | input | 1 | 1 = store, 0 = load |
| req_nc | input | 1 | Non-cacheable access |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | DATA_W | Store data |
| req_sel | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus beat strobe |
| wb_we | output | 1 | Bus write |
| wb_adr | output | ADDR_W | Bus byte address |
| wb_dat_w | output | DATA_W | Bus write data |
| wb_sel | output | DATA_W/8 | Bus byte enables |
| wb_stall | input | 1 | Slave cannot take the beat |
| wb_ack | input | 1 | Beat acknowledged |
| wb_dat_r | input | DATA_W | Bus read data |

## Verification
A hit answers two edges after acceptance: the array read and the output register each take one edge. So the bench drives at falling edges and counts falling edges from acceptance, and it requires the response exactly at the second one. A miss or a non-cacheable load answers one edge after its last acknowledge, so the bench waits for `rsp_valid` and then checks the data and the number of bus beats the slave model counted. Store completion is measured by `req_ready` returning high. The pipelined test samples `req_ready` and the responses at each of five consecutive falling edges.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SINGLE} dc_state_e;
endpackage

// File: rtl/dc_way.sv
module dc_way #(
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 7,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int BYTES     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_we,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [TAG_W-1:0]  tag_in
);
  localparam int AW = IDX_W + WORD_W;

  logic [DATA_W-1:0] mem  [SETS*LINE_WORDS];
  logic [TAG_W-1:0]  tags [SETS];
  logic [SETS-1:0]   vld_q;

  // data array: byte-enabled write, registered read
  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < BYTES; b++)
        if (wr_be[b]) mem[AW'({wr_idx, wr_word})][b*8 +: 8] <= wr_data[b*8 +: 8];
    if (rd_en) begin
      rd_data <= mem[AW'({rd_idx, rd_word})];
      rd_tag  <= tags[rd_idx];
    end
    if (tag_we) tags[tag_idx] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (tag_we) vld_q[tag_idx] <= 1'b1;
      if (rd_en)  rd_vld <= vld_q[rd_idx];
    end
  end
endmodule

// File: rtl/dc_plru.sv
module dc_plru #(
  parameter int SETS   = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             victim
);
  logic [SETS-1:0] vic_q;

  always_ff @(posedge clk) begin
    if (rst) vic_q <= '0;
    else if (upd_en) vic_q[upd_idx] <= ~upd_way;
  end

  assign victim = vic_q[rd_idx];

  AST_VICTIM_FLIP: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (vic_q[$past(upd_idx)] != $past(upd_way))); // R6
endmodule

// File: rtl/dc_wb_seq.sv
module dc_wb_seq #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 3,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  beats,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTES-1:0]  sel,
  output logic              ack_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  beat_o,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_w,
  output logic [BYTES-1:0]  wb_sel,
  input  logic              wb_stall,
  input  logic              wb_ack
);
  logic              busy;
  logic [CNT_W-1:0]  iss_q, ack_q, beats_q;
  logic [ADDR_W-1:0] base_q;

  assign wb_cyc = busy;
  assign wb_stb = busy && (iss_q != beats_q);
  assign wb_adr = base_q + (ADDR_W'(iss_q) << OFF_W);
  assign ack_o  = busy && wb_ack;
  assign beat_o = ack_q;
  assign last_o = ack_o && (ack_q == beats_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; iss_q <= '0; ack_q <= '0; beats_q <= '0;
      base_q <= '0; wb_we <= 1'b0; wb_dat_w <= '0; wb_sel <= '0;
    end else if (start) begin
      busy <= 1'b1; iss_q <= '0; ack_q <= '0; beats_q <= beats;
      base_q <= base; wb_we <= we; wb_dat_w <= wdata; wb_sel <= sel;
    end else begin
      if (wb_stb && !wb_stall) iss_q <= iss_q + CNT_W'(1);
      if (ack_o) ack_q <= ack_q + CNT_W'(1);
      if (last_o) busy <= 1'b0;
    end
  end

  AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_stall) |=> (wb_stb && $stable(wb_adr))); // R10
endmodule

// File: rtl/dc_cache.sv
module dc_cache #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic                  req_nc,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_sel,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  wb_cyc,
  output logic                  wb_stb,
  output logic                  wb_we,
  output logic [ADDR_W-1:0]     wb_adr,
  output logic [DATA_W-1:0]     wb_dat_w,
  output logic [DATA_W/8-1:0]   wb_sel,
  input  logic                  wb_stall,
  input  logic                  wb_ack,
  input  logic [DATA_W-1:0]     wb_dat_r
);
  import dc_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - WORD_W - IDX_W;
  localparam int CNT_W  = WORD_W + 1;

  dc_state_e state;

  // stage 1: request whose array read is in flight
  logic              s1_v, s1_we, s1_nc;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;
  logic [BYTES-1:0]  s1_sel;
  logic [WORD_W-1:0] s1_word;
  logic [IDX_W-1:0]  s1_idx;
  logic [TAG_W-1:0]  s1_tag;

  // refill bookkeeping latched at the start of a miss
  logic              fill_way, single_we;
  logic [IDX_W-1:0]  fill_idx;
  logic [WORD_W-1:0] fill_word;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_hold;

  logic [TAG_W-1:0]  w_tag  [2];
  logic [DATA_W-1:0] w_data [2];
  logic [1:0]        w_vld, hit_w, wr_en, tag_we;
  logic              hit, hit_way, need_bus, acc, filling, victim;
  logic              bus_ack, bus_last;
  logic [CNT_W-1:0]  beat_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_word;
  logic [BYTES-1:0]  wr_be;
  logic [DATA_W-1:0] wr_data;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  assign s1_word = s1_addr[OFF_W +: WORD_W];
  assign s1_idx  = s1_addr[OFF_W+WORD_W +: IDX_W];
  assign s1_tag  = s1_addr[ADDR_W-1 -: TAG_W];

  assign hit      = |hit_w;
  assign hit_way  = hit_w[1];
  assign need_bus = s1_v && (s1_we || s1_nc || !hit);
  assign req_ready = (state == ST_IDLE) && !need_bus;
  assign acc      = req_valid && req_ready;
  assign filling  = (state == ST_FILL);

  assign wr_idx  = filling ? fill_idx : s1_idx;
  assign wr_word = filling ? beat_idx[WORD_W-1:0] : s1_word;
  assign wr_be   = filling ? '1 : s1_sel;
  assign wr_data = filling ? wb_dat_r : s1_wdata;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hit_w[w]  = w_vld[w] && (w_tag[w] == s1_tag) && !s1_nc;
    assign wr_en[w]  = (s1_v && s1_we && hit_w[w]) ||
                       (filling && bus_ack && (fill_way == 1'(w)));
    assign tag_we[w] = filling && bus_last && (fill_way == 1'(w));
    dc_way #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_way (
      .clk(clk), .rst(rst),
      .rd_en(acc), .rd_idx(req_addr[OFF_W+WORD_W +: IDX_W]), .rd_word(req_addr[OFF_W +: WORD_W]),
      .rd_tag(w_tag[w]), .rd_vld(w_vld[w]), .rd_data(w_data[w]),
      .wr_en(wr_en[w]), .wr_idx(wr_idx), .wr_word(wr_word), .wr_be(wr_be), .wr_data(wr_data),
      .tag_we(tag_we[w]), .tag_idx(fill_idx), .tag_in(fill_tag));
  end

  dc_plru #(.SETS(SETS)) u_plru (
    .clk(clk), .rst(rst),
    .upd_en((s1_v && hit) || (filling && bus_last)),
    .upd_idx(filling ? fill_idx : s1_idx),
    .upd_way(filling ? fill_way : hit_way),
    .rd_idx(s1_idx), .victim(victim));

  dc_wb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(need_bus),
    .base((s1_we || s1_nc) ? s1_addr : {s1_tag, s1_idx, {(WORD_W+OFF_W){1'b0}}}),
    .beats((s1_we || s1_nc) ? CNT_W'(1) : CNT_W'(LINE_WORDS)),
    .we(s1_we), .wdata(s1_wdata), .sel(s1_we ? s1_sel : '1),
    .ack_o(bus_ack), .last_o(bus_last), .beat_o(beat_idx),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_stall(wb_stall), .wb_ack(wb_ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; s1_v <= 1'b0; s1_we <= 1'b0; s1_nc <= 1'b0;
      s1_addr <= '0; s1_wdata <= '0; s1_sel <= '0;
      fill_way <= 1'b0; single_we <= 1'b0; fill_idx <= '0; fill_word <= '0;
      fill_tag <= '0; fill_hold <= '0; rsp_v_q <= 1'b0; rsp_d_q <= '0;
    end else begin
      s1_v    <= acc;
      rsp_v_q <= 1'b0;
      if (acc) begin
        s1_we <= req_we; s1_nc <= req_nc; s1_addr <= req_addr;
        s1_wdata <= req_wdata; s1_sel <= req_sel;
      end
      case (state)
        ST_IDLE: begin
          if (need_bus) begin
            state     <= (s1_we || s1_nc) ? ST_SINGLE : ST_FILL;
            fill_way  <= victim;
            fill_idx  <= s1_idx;
            fill_word <= s1_word;
            fill_tag  <= s1_tag;
            single_we <= s1_we;
          end else if (s1_v) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= w_data[hit_way];
          end
        end
        ST_FILL: begin
          if (bus_ack && beat_idx == {1'b0, fill_word}) fill_hold <= wb_dat_r;
          if (bus_last) begin
            state   <= ST_IDLE;
            rsp_v_q <= 1'b1;
            rsp_d_q <= (beat_idx == {1'b0, fill_word}) ? wb_dat_r : fill_hold;
          end
        end
        default: begin
          if (bus_last) begin
            state   <= ST_IDLE;
            rsp_v_q <= !single_we;
            rsp_d_q <= wb_dat_r;
          end
        end
      endcase
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;

  AST_READY_NO_CYC: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !wb_cyc); // R4
  AST_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    s1_v |-> $onehot0(hit_w)); // R5
  AST_FILL_RSP: assert property (@(posedge clk) disable iff (rst)
    (filling && bus_last) |=> (rsp_valid && req_ready)); // R4
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (s1_v && hit && !s1_we) |=> (rsp_valid && !wb_cyc)); // R2
endmodule

// File: tb/test_dc_cache.sv
module test_dc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 4096;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, req_nc = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_sel = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic wb_cyc, wb_stb, wb_we;
  logic [15:0] wb_adr;
  logic [31:0] wb_dat_w;
  logic [3:0]  wb_sel;
  logic wb_stall, wb_ack = 1'b0;
  logic [31:0] wb_dat_r = '0;

  logic [31:0] smem [MEMW];
  logic [31:0] ref_mem [MEMW];
  logic [2:0]  stall_cnt = '0;
  int bus_beats = 0, stall_seen = 0, stall_bad = 0;
  logic prev_stall = 1'b0;
  logic [15:0] prev_adr = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_cache i_dc_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_nc(req_nc), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_sel(req_sel), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_stall(wb_stall), .wb_ack(wb_ack),
    .wb_dat_r(wb_dat_r));

  // pipelined slave: stalls on two of every eight cycles, acks one cycle later
  assign wb_stall = (stall_cnt == 3'd2) || (stall_cnt == 3'd5);

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 3'd1;
    wb_ack <= 1'b0;
    if (prev_stall) begin
      stall_seen <= stall_seen + 1;
      if (!(wb_stb && wb_adr == prev_adr)) stall_bad <= stall_bad + 1;
    end
    prev_stall <= wb_cyc && wb_stb && wb_stall;
    prev_adr   <= wb_adr;
    if (wb_cyc && wb_stb && !wb_stall) begin
      wb_ack    <= 1'b1;
      wb_dat_r  <= smem[wb_adr[13:2]];
      bus_beats <= bus_beats + 1;
      if (wb_we)
        for (int b = 0; b < 4; b++)
          if (wb_sel[b]) smem[wb_adr[13:2]][b*8 +: 8] <= wb_dat_w[b*8 +: 8];
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] a, input bit nc, output logic [31:0] data,
                         output int lat, output int beats);
    int b0;
    b0 = bus_beats;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_nc = nc; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 300) begin @(negedge clk); lat++; end
    data = rsp_data;
    beats = bus_beats - b0;
  endtask

  // exp_beats < 0 means no beat-count check; hit loads also check latency
  task automatic check_load(input logic [15:0] a, input bit nc, input int exp_beats, input string rq);
    logic [31:0] d; int lat, beats;
    do_load(a, nc, d, lat, beats);
    chk(rq, "load data", d, ref_mem[a[13:2]]);
    if (exp_beats >= 0) chk(rq, "bus beats", 32'(beats), 32'(exp_beats));
    if (exp_beats == 0 && !nc) chk(rq, "hit latency", 32'(lat), 32'd2);
  endtask

  task automatic do_store(input logic [15:0] a, input logic [31:0] d, input logic [3:0] sel,
                          input bit nc, input string rq);
    int b0; bit saw_rsp;
    b0 = bus_beats; saw_rsp = 0;
    for (int b = 0; b < 4; b++) if (sel[b]) ref_mem[a[13:2]][b*8 +: 8] = d[b*8 +: 8];
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_nc = nc; req_addr = a; req_wdata = d; req_sel = sel;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    while (!req_ready) begin if (rsp_valid) saw_rsp = 1; @(negedge clk); end
    if (rsp_valid) saw_rsp = 1;
    chk(rq, "store beats", 32'(bus_beats - b0), 32'd1);
    chk(rq, "store gives no response", 32'(saw_rsp), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "wb_cyc", 32'(wb_cyc), 32'd0);
  endtask

  task automatic t_miss_hit;
    logic [31:0] d; int lat, beats;
    do_load(16'h0048, 0, d, lat, beats);               // R1 first access misses, R4 refill
    chk("R4", "miss data", d, ref_mem[16'h0048 >> 2]);
    chk("R4", "refill beats", 32'(beats), 32'd4);
    chk("R4", "miss slower than hit", 32'(lat > 2), 32'd1);
    check_load(16'h0044, 0, 0, "R5");                  // rest of line now present
    check_load(16'h004C, 0, 0, "R2");
  endtask

  task automatic t_pipelined;
    logic [15:0] al [3];
    al[0] = 16'h0040; al[1] = 16'h0044; al[2] = 16'h004C;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R3", "back-to-back rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R3", "back-to-back data", rsp_data, ref_mem[al[i-2][13:2]]);
      end
      if (i < 3) begin
        chk("R3", "ready stays high", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_we = 1'b0; req_nc = 1'b0; req_addr = al[i];
      end else req_valid = 1'b0;
    end
  endtask

  task automatic t_conflict;
    check_load(16'h0074, 0, 4, "R6");  // fills way0
    check_load(16'h0274, 0, 4, "R6");  // fills way1
    check_load(16'h0074, 0, 0, "R6");  // hit way0, victim -> way1
    check_load(16'h0478, 0, 4, "R6");  // evicts 0x0274
    check_load(16'h0070, 0, 0, "R6");  // survivor still hits
    check_load(16'h0270, 0, 4, "R6");  // evicted line misses
  endtask

  task automatic t_store_hit;
    do_store(16'h0074, 32'hDEADBEEF, 4'b0011, 0, "R7");
    check_load(16'h0074, 0, 0, "R7");   // merged bytes, still a hit
  endtask

  task automatic t_store_miss;
    do_store(16'h0624, 32'h12345678, 4'b1111, 0, "R8");
    check_load(16'h0624, 0, 4, "R8");   // not allocated by the store
  endtask

  task automatic t_nc;
    check_load(16'h0074, 1, 1, "R9");   // present line, bypass
    do_store(16'h0900, 32'hCAFEF00D, 4'b1111, 1, "R9");
    check_load(16'h0074, 0, 0, "R9");   // arrays untouched
    check_load(16'h0A04, 1, 1, "R9");
    check_load(16'h0A04, 0, 4, "R9");   // nc load did not allocate
  endtask

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      smem[i]    = 32'hA5000000 ^ (32'(i) * 32'h00010003);
      ref_mem[i] = 32'hA5000000 ^ (32'(i) * 32'h00010003);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_miss_hit;
    t_pipelined;
    t_conflict;
    t_store_hit;
    t_store_miss;
    t_nc;
    repeat (3) @(negedge clk);
    chk("R10", "stalled beats seen", 32'(stall_seen > 0), 32'd1);
    chk("R10", "stalled beat held", 32'(stall_bad), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule